// File: doc/BRIEF.md
# Switch Bank to BCD Digit Serial Link

The block reads an eight-position switch bank and shows on a 4-bit BCD output which switch is closed. The code is not produced next to the switches. A transmitter reduces the switch state to a code: digit n for switch n alone, zero for no closure, and an error code when more than one switch is closed. It wraps the code in an 8-bit frame and shifts that frame, most significant bit first, onto a one-wire serial link. A receiver on the same clock shifts the link into an 8-bit register and recognises a complete frame by its two marker bits. It then updates a registered 4-bit code, which drives an external seven-segment decoder.

The frame is `1, 0, 0, c3, c2, c1, c0, 1`, where bit 7 and bit 0 are the markers and bits 6..1 form a 6-bit digit field. After each frame the transmitter sends eight zero bits, so one frame repeats every 16 clocks. A marker pair can then only line up with a true frame. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `swlink_top`

## Requirements
- R1: With only switch input bit k (k = 0..7) set, `bcd_out` settles to k+1 (switch n gives digit n).
- R2: With two or more switch bits set, `bcd_out` settles to 4'b1110.
- R3: With no switch bit set, `bcd_out` settles to 4'b0000.
- R4: `link_bit` repeats a 16-clock pattern. It sends the frame bits 1, 0, 0, c3, c2, c1, c0, 1 (MSB first, c being the code) on eight consecutive clocks, then 0 on the next eight.
- R5: The code is latched at the clock edge that launches the frame's first marker bit. A switch change after that edge affects only the next frame.
- R6: `bcd_out` changes only at the 9th clock edge after a frame's launch edge, when the receive register holds both markers. At every other edge it holds its value.
- R7: The receiver maps a digit field above 8 to 4'b1110, so `bcd_out` only ever takes the values 0..8 or 14.
- R8: While `rst_n` is low, `bcd_out` is 4'b0000 and `link_bit` is 0, and both shift registers are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for transmitter and receiver, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| sw_in | input | 8 | Switch bank, bit k high means switch k+1 is closed |
| link_bit | output | 1 | Serial line from the transmitter to the receiver |
| bcd_out | output | 4 | Registered BCD code for the seven-segment decoder |

## Verification
On every cycle the assertions check the following. The encoder gives the error code for multiple closures and zero for none. The line carries a marker right after each load and zero throughout the gap. The output never takes a value outside 0..8 and 14, and it stays stable unless a framed window was present. Only the bench scenarios can show the rest: the correct digit for each single switch, the exact bit order of a frame on the line, and that a change made mid-frame is deferred to the next frame with the output moving on exactly the ninth edge. They also show that the output clears and recovers around a reset.

// File: rtl/swlink_pkg.sv
package swlink_pkg;
  localparam int SW_N      = 8;   // switch positions
  localparam int CODE_W    = 4;   // BCD code width
  localparam int FRAME_W   = 8;   // frame length in bits
  localparam int GAP_BITS  = 8;   // zero bits after each frame
  localparam int ERR_VAL   = 14;  // error code value
  localparam int PERIOD    = FRAME_W + GAP_BITS;
  localparam int CNT_W     = $clog2(PERIOD);
  localparam int FIELD_W   = FRAME_W - 2;
  localparam int FILL_W    = FIELD_W - CODE_W;
endpackage

// File: rtl/swlink_enc.sv
module swlink_enc
  import swlink_pkg::*;
#(
  parameter int NSW  = SW_N,
  parameter int CW   = CODE_W,
  parameter int EVAL = ERR_VAL
) (
  input  logic [NSW-1:0] sw,
  output logic [CW-1:0]  code
);
  localparam int HIT_W = $clog2(NSW + 1);

  logic [HIT_W-1:0] hits;
  logic [CW-1:0]    pos;

  always_comb begin
    hits = '0;
    pos  = '0;
    for (int i = 0; i < NSW; i++) begin
      if (sw[i]) begin
        hits = hits + 1'b1;
        pos  = CW'(i + 1);
      end
    end
  end

  always_comb begin
    if (hits == '0)
      code = '0;
    else if (hits == HIT_W'(1))
      code = pos;
    else
      code = CW'(EVAL);
  end
endmodule

// File: rtl/swlink_tx.sv
module swlink_tx
  import swlink_pkg::*;
#(
  parameter int CW  = CODE_W,
  parameter int FW  = FRAME_W,
  parameter int GAP = GAP_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] code_in,
  output logic          ser_out
);
  localparam int PER  = FW + GAP;
  localparam int CW_C = $clog2(PER);
  localparam int FILL = FW - 2 - CW;

  logic [CW_C-1:0] cnt_q, cnt_d;
  logic [FW-1:0]   sr_q, sr_d;
  logic            load;
  logic [FW-1:0]   frame;

  assign frame = {1'b1, {FILL{1'b0}}, code_in, 1'b1};
  assign load  = (cnt_q == '0);

  always_comb begin
    if (cnt_q == CW_C'(PER - 1))
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    if (load)
      sr_d = frame;
    else
      sr_d = {sr_q[FW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
    end
  end

  assign ser_out = sr_q[FW-1];

  AST_TX_MARK_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW_C'(1)) |-> ser_out); // R4

  AST_TX_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q > CW_C'(FW)) || (cnt_q == '0)) |-> !ser_out); // R4
endmodule

// File: rtl/swlink_rx.sv
module swlink_rx
  import swlink_pkg::*;
#(
  parameter int CW   = CODE_W,
  parameter int FW   = FRAME_W,
  parameter int MAXD = SW_N,
  parameter int EVAL = ERR_VAL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_in,
  output logic [CW-1:0] code_out
);
  localparam int FLD = FW - 2;

  logic [FW-1:0]  sr_q, sr_d;
  logic [CW-1:0]  out_q, out_d;
  logic [FLD-1:0] field;
  logic           framed;
  logic [CW-1:0]  decoded;

  assign sr_d   = {sr_q[FW-2:0], ser_in};
  assign framed = sr_q[FW-1] & sr_q[0];
  assign field  = sr_q[FW-2:1];

  always_comb begin
    if (field > FLD'(MAXD))
      decoded = CW'(EVAL);
    else
      decoded = field[CW-1:0];
  end

  always_comb begin
    if (framed)
      out_d = decoded;
    else
      out_d = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      out_q <= '0;
    end else begin
      sr_q  <= sr_d;
      out_q <= out_d;
    end
  end

  assign code_out = out_q;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !framed |=> $stable(code_out)); // R6

  AST_RX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_out <= CW'(MAXD)) || (code_out == CW'(EVAL))); // R7
endmodule

// File: rtl/swlink_top.sv
module swlink_top
  import swlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW_N-1:0]   sw_in,
  output logic              link_bit,
  output logic [CODE_W-1:0] bcd_out
);
  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic [CODE_W-1:0] enc_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rs_q <= '0;
    else
      rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  swlink_enc #(.NSW(SW_N), .CW(CODE_W), .EVAL(ERR_VAL)) u_enc (
    .sw   (sw_in),
    .code (enc_code)
  );

  swlink_tx #(.CW(CODE_W), .FW(FRAME_W), .GAP(GAP_BITS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .code_in (enc_code),
    .ser_out (link_bit)
  );

  swlink_rx #(.CW(CODE_W), .FW(FRAME_W), .MAXD(SW_N), .EVAL(ERR_VAL)) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ser_in   (link_bit),
    .code_out (bcd_out)
  );

  AST_ENC_MULTI_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sw_in) > 1) |-> (enc_code == CODE_W'(ERR_VAL))); // R2

  AST_ENC_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_in == '0) |-> (enc_code == '0)); // R3

  AST_RST_CLEAR: assert property (@(posedge clk)
    !rst_n |-> ((bcd_out == '0) && !link_bit)); // R8
endmodule

// File: tb/sim_swlink_top.sv
`timescale 1ns/1ps
module sim_swlink_top;
  localparam real HALF = 2.5;

  logic       clk;
  logic       rst_n;
  logic [7:0] sw_in;
  logic       link_bit;
  logic [3:0] bcd_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  swlink_top u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_in    (sw_in),
    .link_bit (link_bit),
    .bcd_out  (bcd_out)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  // {switches, expected code, tag index}
  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    {8'h00, 4'h0, 4'd3}, {8'h01, 4'h1, 4'd1}, {8'h02, 4'h2, 4'd1},
    {8'h04, 4'h3, 4'd1}, {8'h08, 4'h4, 4'd1}, {8'h10, 4'h5, 4'd1},
    {8'h20, 4'h6, 4'd1}, {8'h40, 4'h7, 4'd1}, {8'h80, 4'h8, 4'd1},
    {8'h03, 4'hE, 4'd2}, {8'hFF, 4'hE, 4'd2}, {8'h81, 4'hE, 4'd2},
    {8'h18, 4'hE, 4'd7}, {8'h00, 4'h0, 4'd3}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // returns at the negedge where the first marker of a frame is on the line
  task automatic wait_frame();
    int zeros = 0;
    forever begin
      @(negedge clk);
      if (link_bit === 1'b1 && zeros >= 8) break;
      if (link_bit === 1'b0) zeros++; else zeros = 0;
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    logic [15:0] exp_pat;
    rst_n = 1'b0;
    sw_in = 8'h00;
    cycles(3);
    check("R8 reset bcd", 16'(bcd_out), 16'h0);
    check("R8 reset line", 16'(link_bit), 16'h0);
    @(negedge clk) rst_n = 1'b1;
    cycles(40);

    for (int v = 0; v < NV; v++) begin
      sw_in = VEC[v][15:8];
      cycles(40);
      case (VEC[v][3:0])
        4'd1: check("R1 single switch", 16'(bcd_out), 16'(VEC[v][7:4]));
        4'd2: check("R2 multiple switches", 16'(bcd_out), 16'(VEC[v][7:4]));
        4'd3: check("R3 no switch", 16'(bcd_out), 16'(VEC[v][7:4]));
        default: check("R7 range map", 16'(bcd_out), 16'(VEC[v][7:4]));
      endcase
    end

    // R4: line pattern for code 5
    sw_in = 8'h10;
    cycles(40);
    wait_frame();
    pat = '0;
    pat[15] = link_bit;
    for (int i = 14; i >= 0; i--) begin
      @(negedge clk);
      pat[i] = link_bit;
    end
    exp_pat = {1'b1, 2'b00, 4'h5, 1'b1, 8'h00};
    check("R4 frame bits", pat, exp_pat);

    // R5/R6: change right after launch edge
    sw_in = 8'h04;
    cycles(40);
    wait_frame();
    sw_in = 8'h40;
    cycles(9);
    check("R5 latched old value", 16'(bcd_out), 16'h3);
    cycles(15);
    check("R6 held until update edge", 16'(bcd_out), 16'h3);
    cycles(1);
    check("R6 update on ninth edge", 16'(bcd_out), 16'h7);

    // R8: reset mid-run
    sw_in = 8'h80;
    cycles(40);
    check("R1 before reset", 16'(bcd_out), 16'h8);
    #1 rst_n = 1'b0;
    #1;
    check("R8 async clear bcd", 16'(bcd_out), 16'h0);
    check("R8 async clear line", 16'(link_bit), 16'h0);
    cycles(4);
    check("R8 held in reset", 16'(bcd_out), 16'h0);
    @(negedge clk) rst_n = 1'b1;
    cycles(40);
    check("R1 after reset", 16'(bcd_out), 16'h8);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule